// File: doc/BRIEF.md
# Associative Memory Road Finder

This block holds a bank of precomputed track patterns ("roads"). Each road is a set of coarse bin identifiers, one for each detector layer. During an event, hits arrive one per clock as a layer number and a coarse bin. Every loaded road compares each hit against its own bin for that layer in the same cycle. When a road's bin matches, the road sets the flag for that layer. A road whose flags are all set has matched.

When the end-of-event input arrives, the block stops taking hits. It then emits the addresses of the matched roads, one per accepted cycle, in ascending order. The final word carries a last flag. An event with no matched road produces a single word marked both empty and last. The bank is written through a load port, one road per cycle, and only while no event is in progress. One instance serves one detector wedge, so several instances can run side by side with separate banks.

An event of N hits that matches M roads takes N cycles to collect and max(M,1) cycles to drain when the consumer is always ready. No search over hit combinations takes place.

Top module: `am_road_finder`

## Requirements
- R1: After synchronous reset, road_valid is 0, hit_ready is 1, and no road is loaded. An event on an empty bank emits only the empty end marker.
- R2: A load writes load_bins into the road at load_addr in one cycle. The bin for layer l sits at load_bins[l*BIN_W +: BIN_W]. A load is accepted only while idle, meaning no hit or end-of-event has been taken since the last event finished. A load during collection or output is ignored.
- R3: hit_ready is 1 in every cycle except the output phase. An accepted hit (hit_layer, hit_bin) sets that layer's flag in every loaded road whose bin for that layer equals hit_bin, all in the same cycle.
- R4: A road matches only when every one of its 4 layers has seen an equal bin during the event. Repeated hits are harmless, and hits on other bins leave its flags unchanged.
- R5: end_of_event is taken when hit_ready is 1. It ends collection, and road_valid is 1 in the cycle after it is taken.
- R6: Matched road addresses appear in strictly ascending order. A word advances only on a cycle with road_valid and road_ready both 1, and the word is held unchanged while road_ready is 0.
- R7: The final word of every event has road_last set. An event with no match emits exactly one word, with road_empty=1, road_last=1 and road_addr=0.
- R8: All layer flags clear between events, so hits from an earlier event never count toward a later match.
- R9: The cycle after the last word is accepted, road_valid is 0 and hit_ready is 1. An event with M matches takes max(M,1) accepted output cycles.
- R10: A road never loaded since reset never matches, whatever hits arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one road into the bank |
| load_addr | input | ADDR_W | Road address to write |
| load_bins | input | LAYERS*BIN_W | Per-layer coarse bins, layer l at bits l*BIN_W |
| hit_valid | input | 1 | Hit word present |
| hit_ready | output | 1 | Block takes hits and end-of-event |
| hit_layer | input | LAYER_W | Layer of the hit |
| hit_bin | input | BIN_W | Coarse bin of the hit |
| end_of_event | input | 1 | Closes the current event |
| road_valid | output | 1 | Output word present |
| road_ready | input | 1 | Consumer accepts the output word |
| road_addr | output | ADDR_W | Matched road address |
| road_last | output | 1 | Final word of the event |
| road_empty | output | 1 | Event had no matched road |

## Verification
A hit or a load taken at a rising edge acts at that edge. End-of-event makes road_valid visible right after the same edge, and each output handshake moves to the next word at the edge where it happens. The bench drives inputs on the falling edge and reads results one time unit after the rising edge that should produce them. This lets it check that the first output word appears in the cycle right after end-of-event. It then compares every output cycle, including cycles held back by road_ready, against a list of roads its own model expects. After the final word it checks that the block is back to taking hits.

// File: rtl/am_pkg.sv
package am_pkg;

    localparam int DEF_LAYERS   = 4;
    localparam int DEF_PATTERNS = 128;
    localparam int DEF_BIN_W    = 8;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_COLLECT = 2'd1,
        PH_EMIT    = 2'd2
    } phase_e;

    // Phase sequencing shared by the control block.
    function automatic phase_e next_phase(phase_e cur, logic eoe_take,
                                          logic hit_take, logic pop_last);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_IDLE:    if (eoe_take) nxt = PH_EMIT;
                        else if (hit_take) nxt = PH_COLLECT;
            PH_COLLECT: if (eoe_take) nxt = PH_EMIT;
            PH_EMIT:    if (pop_last) nxt = PH_IDLE;
            default:    nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/am_pattern_cell.sv
module am_pattern_cell #(
    parameter int LAYERS  = 4,
    parameter int BIN_W   = 8,
    parameter int LAYER_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [LAYERS*BIN_W-1:0]   wr_bins,
    input  logic                      hit_fire,
    input  logic [LAYER_W-1:0]        hit_layer,
    input  logic [BIN_W-1:0]          hit_bin,
    input  logic                      kill,
    input  logic                      clr,
    output logic                      full
);

    logic [LAYERS*BIN_W-1:0] bins_q;
    logic                    loaded_q;
    logic [LAYERS-1:0]       seen_q;
    logic [BIN_W-1:0]        my_bin;
    logic                    hit_here;

    assign my_bin   = bins_q[hit_layer*BIN_W +: BIN_W];
    assign hit_here = hit_fire && (my_bin == hit_bin);

    always_ff @(posedge clk) begin
        if (rst) begin
            bins_q   <= '0;
            loaded_q <= 1'b0;
        end else if (wr_en) begin
            bins_q   <= wr_bins;
            loaded_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr || kill) begin
            seen_q <= '0;
        end else if (hit_here) begin
            seen_q[hit_layer] <= 1'b1;
        end
    end

    assign full = loaded_q && (&seen_q);

    // R4
    seen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hit_fire && !clr && !kill) |=> $stable(seen_q));

endmodule

// File: rtl/am_first_set.sv
module am_first_set #(
    parameter int WIDTH = 128,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/am_phase_ctrl.sv
module am_phase_ctrl
    import am_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit_valid,
    input  logic eoe,
    input  logic load_en,
    input  logic road_ready,
    input  logic last_word,
    output logic hit_ready,
    output logic hit_fire,
    output logic load_take,
    output logic road_valid,
    output logic pop,
    output logic clr_all
);

    phase_e phase_q;
    logic   eoe_take;

    assign hit_ready  = (phase_q != PH_EMIT);
    assign hit_fire   = hit_valid && hit_ready;
    assign eoe_take   = eoe && hit_ready;
    assign load_take  = load_en && (phase_q == PH_IDLE);
    assign road_valid = (phase_q == PH_EMIT);
    assign pop        = road_valid && road_ready;
    assign clr_all    = pop && last_word;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_IDLE;
        else     phase_q <= next_phase(phase_q, eoe_take, hit_fire, clr_all);
    end

    // R2
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_fire && !eoe_take) |=> (phase_q != PH_IDLE));

endmodule

// File: rtl/am_road_finder.sv
module am_road_finder
    import am_pkg::*;
#(
    parameter int LAYERS   = DEF_LAYERS,
    parameter int PATTERNS = DEF_PATTERNS,
    parameter int BIN_W    = DEF_BIN_W,
    localparam int LAYER_W = (LAYERS > 1) ? $clog2(LAYERS) : 1,
    localparam int ADDR_W  = (PATTERNS > 1) ? $clog2(PATTERNS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_en,
    input  logic [ADDR_W-1:0]       load_addr,
    input  logic [LAYERS*BIN_W-1:0] load_bins,
    input  logic                    hit_valid,
    output logic                    hit_ready,
    input  logic [LAYER_W-1:0]      hit_layer,
    input  logic [BIN_W-1:0]        hit_bin,
    input  logic                    end_of_event,
    output logic                    road_valid,
    input  logic                    road_ready,
    output logic [ADDR_W-1:0]       road_addr,
    output logic                    road_last,
    output logic                    road_empty
);

    logic [PATTERNS-1:0] full_vec;
    logic [PATTERNS-1:0] rest_vec;
    logic [ADDR_W-1:0]   first_idx;
    logic                any_full;
    logic                hit_fire;
    logic                load_take;
    logic                pop;
    logic                clr_all;
    logic                last_word;

    am_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .hit_valid  (hit_valid),
        .eoe        (end_of_event),
        .load_en    (load_en),
        .road_ready (road_ready),
        .last_word  (last_word),
        .hit_ready  (hit_ready),
        .hit_fire   (hit_fire),
        .load_take  (load_take),
        .road_valid (road_valid),
        .pop        (pop),
        .clr_all    (clr_all)
    );

    for (genvar g = 0; g < PATTERNS; g++) begin : g_bank
        am_pattern_cell #(
            .LAYERS  (LAYERS),
            .BIN_W   (BIN_W),
            .LAYER_W (LAYER_W)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (load_take && (load_addr == ADDR_W'(g))),
            .wr_bins   (load_bins),
            .hit_fire  (hit_fire),
            .hit_layer (hit_layer),
            .hit_bin   (hit_bin),
            .kill      (pop && any_full && (first_idx == ADDR_W'(g))),
            .clr       (clr_all),
            .full      (full_vec[g])
        );
    end

    am_first_set #(.WIDTH(PATTERNS)) u_pick (
        .vec (full_vec),
        .idx (first_idx),
        .any (any_full)
    );

    assign rest_vec   = full_vec & ~(PATTERNS'(1) << first_idx);
    assign last_word  = ~|rest_vec;
    assign road_addr  = first_idx;
    assign road_last  = road_valid && last_word;
    assign road_empty = road_valid && !any_full;

    // R6
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (road_valid && road_ready && !road_last) |=>
        (road_valid && (road_addr > $past(road_addr))));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (road_valid && !road_ready) |=>
        (road_valid && $stable(road_addr) && $stable(road_last)));

    // R7
    empty_last_chk: assert property (@(posedge clk) disable iff (rst)
        road_empty |-> (road_last && road_addr == '0));

    // R9
    return_chk: assert property (@(posedge clk) disable iff (rst)
        (road_valid && road_ready && road_last) |=> (!road_valid && hit_ready));

    // R5
    eoe_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (end_of_event && hit_ready) |=> road_valid);

endmodule

// File: tb/test_am_road_finder.sv
module test_am_road_finder;

    localparam int CLK_PERIOD = 10;
    localparam int L  = 4;
    localparam int P  = 128;
    localparam int BW = 8;
    localparam int AW = 7;
    localparam int LW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [L*BW-1:0] load_bins = '0;
    logic hit_valid = 1'b0;
    logic hit_ready;
    logic [LW-1:0] hit_layer = '0;
    logic [BW-1:0] hit_bin = '0;
    logic end_of_event = 1'b0;
    logic road_valid;
    logic road_ready = 1'b0;
    logic [AW-1:0] road_addr;
    logic road_last;
    logic road_empty;

    int checks = 0;
    int errors = 0;

    logic [BW-1:0] m_pat [P][L];
    bit            m_val [P];
    bit            m_seen [P][L];

    always #(CLK_PERIOD/2) clk = ~clk;

    am_road_finder i_am_road_finder (
        .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
        .load_bins(load_bins), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_layer(hit_layer), .hit_bin(hit_bin), .end_of_event(end_of_event),
        .road_valid(road_valid), .road_ready(road_ready), .road_addr(road_addr),
        .road_last(road_last), .road_empty(road_empty)
    );

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(int addr, int b0, int b1, int b2, int b3, bit accept);
        @(negedge clk);
        load_en = 1'b1;
        load_addr = AW'(addr);
        load_bins = {BW'(b3), BW'(b2), BW'(b1), BW'(b0)};
        @(posedge clk); #1;
        load_en = 1'b0;
        if (accept) begin
            m_pat[addr][0] = BW'(b0); m_pat[addr][1] = BW'(b1);
            m_pat[addr][2] = BW'(b2); m_pat[addr][3] = BW'(b3);
            m_val[addr] = 1'b1;
        end
    endtask

    task automatic do_hit(int lay, int bin);
        @(negedge clk);
        check(hit_ready == 1'b1, "R3 hit_ready", int'(hit_ready), 1);
        hit_valid = 1'b1;
        hit_layer = LW'(lay);
        hit_bin = BW'(bin);
        @(posedge clk); #1;
        hit_valid = 1'b0;
        for (int p = 0; p < P; p++)
            if (m_val[p] && m_pat[p][lay] == BW'(bin)) m_seen[p][lay] = 1'b1;
    endtask

    // Closes the event and drains the roads; optionally tries a load while emitting.
    task automatic close_event(int ready_pct, bit load_in_emit);
        int exp_q[$];
        int k;
        int guard;
        bit done;
        bit r;
        for (int p = 0; p < P; p++)
            if (m_val[p] && m_seen[p][0] && m_seen[p][1] && m_seen[p][2] && m_seen[p][3])
                exp_q.push_back(p);
        @(negedge clk);
        end_of_event = 1'b1;
        @(posedge clk); #1;
        end_of_event = 1'b0;
        check(road_valid == 1'b1, "R5 road_valid after eoe", int'(road_valid), 1);
        check(hit_ready == 1'b0, "R3 hit_ready in output", int'(hit_ready), 0);
        if (load_in_emit) do_load(120, 0, 0, 0, 0, 1'b0);
        k = 0; guard = 0; done = 1'b0;
        while (!done && guard < 2000) begin
            guard++;
            @(negedge clk);
            r = (($urandom % 100) < ready_pct);
            road_ready = r;
            check(road_valid == 1'b1, "R6 road_valid", int'(road_valid), 1);
            if (exp_q.size() == 0) begin
                check(road_empty == 1'b1, "R7 empty flag", int'(road_empty), 1);
                check(road_last == 1'b1, "R7 empty last", int'(road_last), 1);
                check(road_addr == '0, "R7 empty addr", int'(road_addr), 0);
                if (r) done = 1'b1;
            end else begin
                check(int'(road_addr) == exp_q[k], "R6 road_addr", int'(road_addr), exp_q[k]);
                check(road_last == (k == exp_q.size() - 1), "R7 road_last",
                      int'(road_last), int'(k == exp_q.size() - 1));
                check(road_empty == 1'b0, "R7 not empty", int'(road_empty), 0);
                if (r) begin
                    k++;
                    if (k == exp_q.size()) done = 1'b1;
                end
            end
            @(posedge clk); #1;
            road_ready = 1'b0;
        end
        check(done, "R9 drain completed", int'(done), 1);
        check(road_valid == 1'b0, "R9 valid drops", int'(road_valid), 0);
        check(hit_ready == 1'b1, "R9 ready returns", int'(hit_ready), 1);
        for (int p = 0; p < P; p++)
            for (int l = 0; l < L; l++) m_seen[p][l] = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < P; p++) begin
            m_val[p] = 1'b0;
            for (int l = 0; l < L; l++) begin
                m_pat[p][l] = '0;
                m_seen[p][l] = 1'b0;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state and empty bank
        check(road_valid == 1'b0, "R1 road_valid", int'(road_valid), 0);
        check(hit_ready == 1'b1, "R1 hit_ready", int'(hit_ready), 1);
        do_hit(0, 0); do_hit(1, 0); do_hit(2, 0); do_hit(3, 0);
        close_event(100, 1'b0);

        // R2: fill most of the bank with small random bins
        for (int p = 0; p < 120; p++)
            do_load(p, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, 1'b1);
        do_load(120, 5, 6, 7, 8, 1'b1);

        // R4: partial coverage does not match
        do_hit(0, 5); do_hit(1, 6); do_hit(2, 7);
        close_event(100, 1'b0);
        // R8: remaining layer alone in next event does not complete road 120
        do_hit(3, 8);
        close_event(100, 1'b0);
        // R4: full coverage with duplicates matches, R2 load during output ignored
        do_hit(0, 5); do_hit(0, 5); do_hit(1, 6); do_hit(2, 7); do_hit(3, 8);
        close_event(60, 1'b1);
        do_hit(3, 8); do_hit(2, 7); do_hit(1, 6); do_hit(0, 5);
        close_event(100, 1'b0);

        // R2 and R10: load during collection ignored, road 121 stays unloaded
        do_hit(0, 9);
        do_load(121, 9, 9, 9, 9, 1'b0);
        do_hit(1, 9); do_hit(2, 9); do_hit(3, 9);
        close_event(100, 1'b0);

        // R2: idle load of the top address takes effect
        do_load(127, 9, 9, 9, 9, 1'b1);
        do_hit(0, 9); do_hit(1, 9); do_hit(2, 9); do_hit(3, 9);
        close_event(50, 1'b0);

        // R10: every low bin on every layer, unloaded roads stay silent
        for (int l = 0; l < L; l++)
            for (int b = 0; b < 4; b++) do_hit(l, b);
        close_event(80, 1'b0);

        // R3 R4 R6: random events with mixed back-pressure
        for (int e = 0; e < 40; e++) begin
            int n;
            int pct;
            n = $urandom % 14;
            pct = (e % 3 == 0) ? 100 : ((e % 3 == 1) ? 70 : 30);
            for (int h = 0; h < n; h++) do_hit($urandom % 4, $urandom % 5);
            close_event(pct, 1'b0);
        end

        finish_run();
    end

endmodule